// File: doc/BRIEF.md
# GPIO Bank Lock Guard

This block protects the per-pin configuration of a multi-bank GPIO controller against stray writes. It keeps one 32-bit lock word per bank, one bit per pin, where a 1 marks the pin as locked and a 0 leaves it open for configuration. The words are driven out side by side on `lockWords` so that the pin logic can refuse configuration writes to locked pins.

Changing a lock word takes two register writes in a row. First the key `0x00A5A501` goes to the password register at byte offset `0x520`. Then the new value goes to the bank's lock word at `0x500 + 4*n`. The key arms the unit for exactly one write. Any other write clears the arming, so software must present the key again before each lock-word update. Lock words can be read back, which allows a read-modify-write through the password sequence. A lock-word write made without arming changes nothing and raises a sticky violation flag. The flag can be read in a status register and is cleared by writing that register.

Top module: `gpio_bank_lock`

## Requirements
- R1: After reset every lock word is `0xFFFFFFFF`, the unit is disarmed, the violation flag is 0 and `busRdData` is 0.
- R2: A write of exactly `0x00A5A501` to offset `0x520` arms the unit. A lock-word write (offset `0x500 + 4*n`, n below NUM_BANKS) in the next write cycle loads the whole word into bank n. The new word shows on `lockWords[32*n +: 32]` after that clock edge.
- R3: The key is used up by the lock-word write it enabled. A second lock-word write that is not preceded by a new key write leaves every word unchanged.
- R4: A lock-word write made while disarmed changes no lock word and sets the violation flag. The flag stays set until it is cleared by R8.
- R5: A write to `0x520` with any value other than the key leaves the unit disarmed, even if it was armed.
- R6: A write to any address other than `0x520` disarms the unit. This covers the status register, unmapped addresses and misaligned addresses such as `0x502`. Cycles with reads only, or idle cycles, do not change the arming.
- R7: A read drives `busRdData` in the cycle after `busRdEn`, and the value holds until the next read. Lock-word offsets return the word. Status offset `0x524` returns bit 0 = armed and bit 1 = violation, with all other bits 0. The password offset and unmapped addresses return 0.
- R8: A write to `0x524` with bit 1 set clears the violation flag. A write to `0x524` with bit 1 clear leaves the flag as it was.
- R9: When a read and a write hit the same address in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for this cycle |
| busRdEn | input | 1 | Read strobe for this cycle |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered, valid the cycle after busRdEn |
| lockWords | output | NUM_BANKS*32 | All bank lock words, bank n at bits 32*n+31..32*n |
| lockViolation | output | 1 | Sticky flag for a disarmed lock-word write |

## Verification
A read and a write can fall in the same cycle on the same address. This matters most for a lock word being updated, or for the status register while an unarmed lock write sets the violation flag. The bench provokes this case directly with a key write followed by a combined read and write of bank 0. It also mixes combined reads and writes into the random traffic at random addresses. Each sampled read is judged against a bench model that captures the read value from its state before applying the write, so a read that returns the new value is reported.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int MAX_BANKS  = 8;
  localparam int BANK_IDX_W = 3;
  localparam int REG_W      = 32;
  localparam int STAT_ARMED_BIT = 0;
  localparam int STAT_VIOL_BIT  = 1;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_LOCK   = 2'd1,
    RD_STATUS = 2'd2
  } rdSel_e;

  // strobes from control to the word store
  typedef struct packed {
    logic                  lockWrEn;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] bank;
  } lockStrobe_t;
endpackage

// File: rtl/lock_arm_ctrl.sv
module lock_arm_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                NUM_BANKS = 8,
  parameter logic [ADDR_W-1:0] LOCK_BASE = 12'h500,
  parameter logic [ADDR_W-1:0] PWD_ADDR  = 12'h520,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h524,
  parameter logic [REG_W-1:0]  KEY       = 32'h00A5_A501
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output lockStrobe_t       strb,
  output logic              armed,
  output logic              violation
);
  localparam int SLOT_LSB = BANK_IDX_W + 2;

  logic                  inLockWin;
  logic [BANK_IDX_W-1:0] slotIdx;
  logic                  isLock;
  logic                  isPwd;
  logic                  isStat;
  logic                  keyOk;
  logic                  armedNxt;
  logic                  violNxt;

  // address decode
  assign slotIdx   = busAddr[SLOT_LSB-1:2];
  assign inLockWin = (busAddr[ADDR_W-1:SLOT_LSB] == LOCK_BASE[ADDR_W-1:SLOT_LSB])
                     && (busAddr[1:0] == 2'b00);
  assign isLock    = inLockWin && (int'(slotIdx) < NUM_BANKS);
  assign isPwd     = (busAddr == PWD_ADDR);
  assign isStat    = (busAddr == STAT_ADDR);
  assign keyOk     = (busWrData == KEY);

  // every write re-decides the arming: only a correct key leaves it set
  always_comb begin
    armedNxt = armed;
    if (busWrEn) armedNxt = isPwd && keyOk;
  end

  always_comb begin
    violNxt = violation;
    if (busWrEn && isLock && !armed)                    violNxt = 1'b1;
    if (busWrEn && isStat && busWrData[STAT_VIOL_BIT])  violNxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      violation <= 1'b0;
    end else begin
      armed     <= armedNxt;
      violation <= violNxt;
    end
  end

  always_comb begin
    strb          = '0;
    strb.lockWrEn = busWrEn && isLock && armed;
    strb.rdEn     = busRdEn;
    strb.bank     = slotIdx;
    if (isLock)      strb.rdSel = RD_LOCK;
    else if (isStat) strb.rdSel = RD_STATUS;
    else             strb.rdSel = RD_ZERO;
  end

  // R2: the key arms the unit
  p_key_arms_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == PWD_ADDR && busWrData == KEY |=> armed);

  // R3: a lock write that goes through uses up the arming
  p_key_consumed_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.lockWrEn |=> !armed);

  // R5: a wrong password disarms
  p_bad_key_disarms_r5: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == PWD_ADDR && busWrData != KEY |=> !armed);

  // R6: a write elsewhere disarms, and a cycle without a write keeps the arming
  p_other_write_disarms_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr != PWD_ADDR |=> !armed);
  p_idle_keeps_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(armed));

  // R4: a disarmed lock write raises the flag, and the flag sticks
  p_unarmed_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && isLock && !armed |=> violation);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    violation && !(busWrEn && busAddr == STAT_ADDR && busWrData[STAT_VIOL_BIT])
    |=> violation);

  // R8: the clear write drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == STAT_ADDR && busWrData[STAT_VIOL_BIT] |=> !violation);
endmodule

// File: rtl/lock_word_store.sv
module lock_word_store
  import gpio_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int LOCK_W   = NUM_BANKS * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobe_t       strb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              armed,
  input  logic              violation,
  output logic [LOCK_W-1:0] lockWords,
  output logic [REG_W-1:0]  rdData
);
  logic [REG_W-1:0] word [NUM_BANKS];
  logic [REG_W-1:0] rdNxt;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        word[b] <= '1;
      else if (strb.lockWrEn && strb.bank == BANK_IDX_W'(b))
        word[b] <= wrData;
    end
    assign lockWords[b*REG_W +: REG_W] = word[b];

    // R2: an accepted write lands in its own bank
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.lockWrEn && strb.bank == BANK_IDX_W'(b) |=> word[b] == $past(wrData));
  end

  // read value from the state before any write of this cycle
  always_comb begin
    rdNxt = '0;
    case (strb.rdSel)
      RD_LOCK: rdNxt = word[strb.bank];
      RD_STATUS: begin
        rdNxt[STAT_ARMED_BIT] = armed;
        rdNxt[STAT_VIOL_BIT]  = violation;
      end
      default: rdNxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNxt;
  end

  // R4 / R3: without an accepted write the words do not move
  p_words_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lockWrEn |=> $stable(lockWords));

  // R7: read data holds between reads, and unmapped reads return zero
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn && strb.rdSel == RD_ZERO |=> rdData == '0);
endmodule

// File: rtl/gpio_bank_lock.sv
module gpio_bank_lock
  import gpio_lock_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                NUM_BANKS = 8,
  parameter logic [ADDR_W-1:0] LOCK_BASE = 12'h500,
  parameter logic [ADDR_W-1:0] PWD_ADDR  = 12'h520,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h524,
  parameter logic [31:0]       KEY       = 32'h00A5_A501,
  localparam int LOCK_W = NUM_BANKS * 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [LOCK_W-1:0] lockWords,
  output logic              lockViolation
);
  lockStrobe_t strb;
  logic        armed;

  lock_arm_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .LOCK_BASE(LOCK_BASE),
    .PWD_ADDR(PWD_ADDR), .STAT_ADDR(STAT_ADDR), .KEY(KEY)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData),
    .strb(strb), .armed(armed), .violation(lockViolation)
  );

  lock_word_store #(.NUM_BANKS(NUM_BANKS)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .armed(armed), .violation(lockViolation),
    .lockWords(lockWords), .rdData(busRdData)
  );
endmodule

// File: tb/test_gpio_bank_lock.sv
`timescale 1ns/1ps
module test_gpio_bank_lock;
  localparam int          NB   = 8;
  localparam logic [11:0] LBASE = 12'h500;
  localparam logic [11:0] PWD  = 12'h520;
  localparam logic [11:0] STAT = 12'h524;
  localparam logic [31:0] KEY  = 32'h00A5_A501;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWrEn = 1'b0;
  logic             busRdEn = 1'b0;
  logic [11:0]      busAddr = '0;
  logic [31:0]      busWrData = '0;
  logic [31:0]      busRdData;
  logic [NB*32-1:0] lockWords;
  logic             lockViolation;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] mWords [NB];
  logic        mArmed;
  logic        mViol;
  logic [31:0] mRd;

  always #2 clk = ~clk;

  gpio_bank_lock i_gpio_bank_lock (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .lockWords(lockWords), .lockViolation(lockViolation)
  );

  function automatic bit isLockA(logic [11:0] a);
    return (a >= LBASE) && (a < LBASE + 12'(4*NB)) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    if (isLockA(a)) return mWords[int'((a - LBASE) >> 2)];
    if (a == STAT)  return {30'b0, mViol, mArmed};
    return 32'h0;
  endfunction

  task automatic modelWrite(logic [11:0] a, logic [31:0] d);
    if (isLockA(a)) begin
      if (mArmed) mWords[int'((a - LBASE) >> 2)] = d;
      else        mViol = 1'b1;
    end else if (a == STAT && d[1]) begin
      mViol = 1'b0;
    end
    mArmed = (a == PWD) && (d == KEY);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int b = 0; b < NB; b++)
      chk({tag, " R2 word"}, lockWords[b*32 +: 32], mWords[b]);
    chk({tag, " R4 flag"}, {31'b0, lockViolation}, {31'b0, mViol});
    chk({tag, " R7 rdata"}, busRdData, mRd);
  endtask

  // one bus cycle: drive at negedge, update the model after the edge
  task automatic busCycle(logic we, logic re, logic [11:0] a, logic [31:0] d);
    logic [31:0] rdExp;
    @(negedge clk);
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
    rdExp = expRead(a);
    @(posedge clk);
    #1;
    if (re) mRd = rdExp;
    if (we) modelWrite(a, d);
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0005_EED5));
    for (int b = 0; b < NB; b++) mWords[b] = 32'hFFFF_FFFF;
    mArmed = 1'b0; mViol = 1'b0; mRd = 32'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values
    checkAll("R1 reset");
    busCycle(0, 1, STAT, 0);
    chk("R1 status after reset", busRdData, 32'h0);

    // R2: key then write bank 3
    busCycle(1, 0, PWD, KEY);
    busCycle(0, 1, STAT, 0);
    chk("R2 armed bit", busRdData, 32'h1);
    busCycle(1, 0, 12'h50C, 32'h0000_00F0);
    checkAll("R2 bank3 write");
    chk("R2 bank3 value", lockWords[3*32 +: 32], 32'h0000_00F0);

    // R3: second write without key is dropped
    busCycle(1, 0, 12'h50C, 32'h0000_0000);
    checkAll("R3 second write");
    chk("R3 bank3 kept", lockWords[3*32 +: 32], 32'h0000_00F0);
    chk("R3 flag raised", {31'b0, lockViolation}, 32'h1);

    // R8: status write without bit1 keeps flag, with bit1 clears
    busCycle(1, 0, STAT, 32'h0000_0001);
    chk("R8 flag kept", {31'b0, lockViolation}, 32'h1);
    busCycle(1, 0, STAT, 32'h0000_0002);
    chk("R8 flag cleared", {31'b0, lockViolation}, 32'h0);

    // R4: disarmed write to bank 0
    busCycle(1, 0, 12'h500, 32'h0);
    checkAll("R4 unarmed");
    busCycle(1, 0, STAT, 32'h2);

    // R5: wrong key disarms
    busCycle(1, 0, PWD, KEY);
    busCycle(1, 0, PWD, KEY ^ 32'h1);
    busCycle(1, 0, 12'h504, 32'h0);
    checkAll("R5 bad key");
    chk("R5 bank1 locked", lockWords[1*32 +: 32], 32'hFFFF_FFFF);

    // R6: reads keep arming, other writes drop it
    busCycle(1, 0, PWD, KEY);
    busCycle(0, 1, 12'h51C, 0);
    busCycle(0, 0, 12'h000, 0);
    busCycle(1, 0, 12'h51C, 32'h0000_0000);
    chk("R6 read keeps arm", lockWords[7*32 +: 32], 32'h0);
    busCycle(1, 0, PWD, KEY);
    busCycle(1, 0, 12'h502, 32'h1234_5678);
    busCycle(1, 0, 12'h518, 32'h0);
    chk("R6 misaligned write disarms", lockWords[6*32 +: 32], 32'hFFFF_FFFF);
    busCycle(1, 0, STAT, 32'h2);

    // R7: readback of lock word, password and unmapped
    busCycle(0, 1, 12'h50C, 0);
    chk("R7 lock read", busRdData, 32'h0000_00F0);
    busCycle(0, 1, PWD, 0);
    chk("R7 password reads zero", busRdData, 32'h0);
    busCycle(0, 1, 12'h600, 0);
    chk("R7 unmapped reads zero", busRdData, 32'h0);

    // R9: read and write of bank 0 in one cycle
    busCycle(1, 0, PWD, KEY);
    busCycle(1, 1, 12'h500, 32'hA5A5_0F0F);
    chk("R9 old value read", busRdData, 32'hFFFF_FFFF);
    checkAll("R9 same cycle");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int          op;
      logic        we;
      logic        re;
      logic [11:0] a;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      re = ($urandom_range(0, 2) == 0);
      we = 1'b1;
      d  = $urandom;
      case (op)
        0, 1, 2: begin a = PWD; if ($urandom_range(0, 3) != 0) d = KEY; end
        3, 4, 5: begin
          a = LBASE + 12'(4 * $urandom_range(0, NB - 1));
          if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
          else if ($urandom_range(0, 3) == 0) d = 32'h0;
        end
        6: a = STAT;
        7: a = ($urandom_range(0, 1) == 0) ? 12'h600 : 12'h502;
        default: begin
          we = 1'b0; re = 1'b1;
          a = ($urandom_range(0, 1) == 0) ? STAT : LBASE + 12'(4 * $urandom_range(0, NB - 1));
        end
      endcase
      busCycle(we, re, a, d);
      checkAll("R9 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule